// File: doc/BRIEF.md
# CAN Bit Time Generator

This block turns the system clock into CAN time quanta and steps each nominal bit through four segments in fixed order: a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. A single programmed phase length sets both phase segments. The propagation segment has its own programmed length.

Two single-clock strobes come out of the block. The transmit strobe marks the first clock of every bit. The sample strobe marks the last clock of phase segment 1. These strobes pace the transceive state machine and its shift registers.

The block also reports when phase segment 2 is running and which segment is current. Software reload timing after a buffer-empty event is bounded by the length of phase segment 2. While the enable is low, the sequence is parked at the start of the sync segment and all outputs are quiet.

Top module: `can_bit_timer`

## Requirements
- R1: A time quantum lasts presc+1 clocks. `tq_tick` is high for exactly the last clock of each quantum while enabled. With presc=0 it is high on every enabled clock.
- R2: A bit lasts 1+P+2*S quanta, where P=prop_len+1 and S=pseg_len+1, so that encodings 0..7 give lengths 1..8. Consecutive `tx_stb` pulses are therefore that many quanta apart.
- R3: `tx_stb` is high for one clock on the first clock of each bit. This includes the first clock in which `en` is high.
- R4: `sample_stb` is high for one clock, on the last clock of phase segment 1. That is clock (1+P+S)*(presc+1)-1 of the bit, counting the bit's first clock as 0.
- R5: `phase2_active` is high on exactly the S*(presc+1) clocks of phase segment 2 and low elsewhere.
- R6: While `en` is low, `tq_tick`, `tx_stb`, `sample_stb` and `phase2_active` are low and `seg_code` is 0. After `en` returns high, the bit restarts at the sync segment, even if `en` was low for a single clock in mid-bit.
- R7: `seg_code` gives the current segment: 0 for sync, 1 for propagation, 2 for phase segment 1 and 3 for phase segment 2.
- R8: While `rst_n` is low with `en` low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low parks the sequence at the sync start |
| presc | input | PRESC_W | Quantum prescaler; divides by presc+1 |
| prop_len | input | LEN_W | Propagation segment length, encoding+1 quanta |
| pseg_len | input | LEN_W | Length of each phase segment, encoding+1 quanta |
| tq_tick | output | 1 | Last clock of each time quantum |
| tx_stb | output | 1 | First clock of each bit |
| sample_stb | output | 1 | Last clock of phase segment 1 |
| phase2_active | output | 1 | High during phase segment 2 |
| seg_code | output | 2 | Current segment code |

## Verification
A wrong prescaler count shows up first. `tq_tick` moves on the first quantum after enable, and every strobe after it shifts with it. A segment counter that stops at the wrong limit changes `seg_code` on the next quantum boundary. The bit then runs short or long, so `sample_stb` and the next `tx_stb` land off their expected clock within one bit. Each clock of two full bits is compared for every vector, so a stale or wrongly cleared state is caught within one quantum of the point where it appears.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PROP = 2'd1,
      SEG_PH1  = 2'd2,
      SEG_PH2  = 2'd3
   } seg_e;
endpackage

// File: rtl/cbt_tq_div.sv
module cbt_tq_div #(
   parameter int PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [PRESC_W-1:0] presc,
   output logic               tq_tick,
   output logic               tq_first
);
   logic [PRESC_W-1:0] pc_q;

   if (PRESC_W < 1) begin : g_bad_w
      $error("cbt_tq_div: PRESC_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            pc_q <= '0;
      else if (!en)          pc_q <= '0;
      else if (pc_q >= presc) pc_q <= '0;
      else                   pc_q <= pc_q + 1'b1;
   end

   assign tq_tick  = en && (pc_q >= presc);
   assign tq_first = en && (pc_q == '0);

   // R1: a tick is followed by a non-tick clock when the divider exceeds one
   assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tq_tick && presc != '0) |=> (!tq_tick || !$stable(presc)));

   // R1: after a tick, the next clock begins a new quantum
   assert_tick_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tq_tick && en) |=> (tq_first || !en));
endmodule

// File: rtl/cbt_seg_seq.sv
module cbt_seg_seq
   import cbt_pkg::*;
#(
   parameter int LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tq_tick,
   input  logic [LEN_W-1:0] prop_len,
   input  logic [LEN_W-1:0] pseg_len,
   output seg_e             seg,
   output logic             seg_last
);
   localparam int NSEG = 4;

   seg_e             seg_q;
   logic [LEN_W-1:0] qcnt_q;
   logic [LEN_W-1:0] lim_tab [NSEG];

   if (LEN_W < 1) begin : g_bad_w
      $error("cbt_seg_seq: LEN_W must be at least 1");
   end

   for (genvar s = 0; s < NSEG; s++) begin : g_lim
      if (s == 0) begin : g_sync
         assign lim_tab[s] = '0;
      end else if (s == 1) begin : g_prop
         assign lim_tab[s] = prop_len;
      end else begin : g_phase
         assign lim_tab[s] = pseg_len;
      end
   end

   assign seg_last = (qcnt_q >= lim_tab[seg_q]);
   assign seg      = seg_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         seg_q  <= SEG_SYNC;
         qcnt_q <= '0;
      end else if (tq_tick) begin
         if (seg_last) begin
            seg_q  <= seg_e'(seg_q + 2'd1);
            qcnt_q <= '0;
         end else begin
            qcnt_q <= qcnt_q + 1'b1;
         end
      end
   end

   // R2: sync lasts one quantum, then propagation follows
   assert_sync_one_tq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && seg_q == SEG_SYNC && tq_tick) |=> (seg_q == SEG_PROP || !en));

   // R5: phase segment 2 holds between quantum boundaries
   assert_ph2_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && seg_q == SEG_PH2 && !tq_tick) |=> (seg_q == SEG_PH2 || !en));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
   import cbt_pkg::*;
#(
   parameter int PRESC_W = 8,
   parameter int LEN_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [PRESC_W-1:0] presc,
   input  logic [LEN_W-1:0]   prop_len,
   input  logic [LEN_W-1:0]   pseg_len,
   output logic               tq_tick,
   output logic               tx_stb,
   output logic               sample_stb,
   output logic               phase2_active,
   output logic [1:0]         seg_code
);
   logic tick_w, first_w, last_w;
   seg_e seg_w;

   cbt_tq_div #(.PRESC_W(PRESC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(en), .presc(presc),
      .tq_tick(tick_w), .tq_first(first_w)
   );

   cbt_seg_seq #(.LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .tq_tick(tick_w),
      .prop_len(prop_len), .pseg_len(pseg_len),
      .seg(seg_w), .seg_last(last_w)
   );

   assign tq_tick       = tick_w;
   assign tx_stb        = first_w && (seg_w == SEG_SYNC);
   assign sample_stb    = tick_w && last_w && (seg_w == SEG_PH1);
   assign phase2_active = en && (seg_w == SEG_PH2);
   assign seg_code      = en ? seg_w : SEG_SYNC;

   // R3 / R4: the two strobes never coincide
   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_stb && sample_stb));

   // R6: nothing moves while disabled
   assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!tq_tick && !tx_stb && !sample_stb && !phase2_active));

   // R5: the sample point hands over to phase segment 2
   assert_sample_to_ph2_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sample_stb) |=> (phase2_active || !en));

   // R3: the end of phase segment 2 starts a new bit
   assert_ph2_end_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(phase2_active) && en) |-> tx_stb);
endmodule

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] presc = '0;
   logic [2:0] prop_len = '0;
   logic [2:0] pseg_len = '0;
   logic       tq_tick, tx_stb, sample_stb, phase2_active;
   logic [1:0] seg_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   can_bit_timer u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .presc(presc),
      .prop_len(prop_len), .pseg_len(pseg_len),
      .tq_tick(tq_tick), .tx_stb(tx_stb), .sample_stb(sample_stb),
      .phase2_active(phase2_active), .seg_code(seg_code)
   );

   // {presc[13:6], prop_len[5:3], pseg_len[2:0]}
   localparam logic [13:0] VEC [6] = '{
      {8'd0, 3'd0, 3'd0},
      {8'd0, 3'd7, 3'd7},
      {8'd3, 3'd1, 3'd2},
      {8'd1, 3'd4, 3'd0},
      {8'd4, 3'd0, 3'd5},
      {8'd2, 3'd7, 3'd3}
   };

   task automatic chk(input int act, input int exp, input string tag, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // expected outputs for clock k of an enabled run
   task automatic check_cycle(input int k, input int q, input int p, input int s);
      int b, m, qi, eseg;
      b  = (1 + p + 2*s) * q;
      m  = k % b;
      qi = m / q;
      eseg = (qi == 0) ? 0 : (qi < 1 + p) ? 1 : (qi < 1 + p + s) ? 2 : 3;
      chk(int'(tq_tick), int'((k % q) == q - 1), "R1", "tq_tick");
      chk(int'(tx_stb), int'(m == 0), "R3", "tx_stb");
      chk(int'(sample_stb), int'(m == (1 + p + s) * q - 1), "R4", "sample_stb");
      chk(int'(phase2_active), int'(qi >= 1 + p + s), "R5", "phase2_active");
      chk(int'(seg_code), eseg, "R7", "seg_code");
      if (k == b)     chk(int'(tx_stb), 1, "R2", "tx_stb at bit length");
      if (k == b - 1) chk(int'(tx_stb), 0, "R2", "tx_stb before bit length");
   endtask

   task automatic check_quiet(input string tag);
      chk(int'(tq_tick), 0, tag, "tq_tick quiet");
      chk(int'(tx_stb), 0, tag, "tx_stb quiet");
      chk(int'(sample_stb), 0, tag, "sample_stb quiet");
      chk(int'(phase2_active), 0, tag, "phase2_active quiet");
      chk(int'(seg_code), 0, tag, "seg_code quiet");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int q, p, s, b;
      // R8: reset state
      repeat (2) @(negedge clk);
      #1 check_quiet("R8");
      @(negedge clk);
      rst_n = 1'b1;
      #1 check_quiet("R8");

      // table of configurations
      for (int v = 0; v < 6; v++) begin
         @(negedge clk);
         en       = 1'b0;
         presc    = VEC[v][13:6];
         prop_len = VEC[v][5:3];
         pseg_len = VEC[v][2:0];
         q = int'(presc) + 1;
         p = int'(prop_len) + 1;
         s = int'(pseg_len) + 1;
         b = (1 + p + 2*s) * q;
         @(negedge clk);
         en = 1'b1;
         for (int k = 0; k < 2*b + 3; k++) begin
            #1 check_cycle(k, q, p, s);
            @(negedge clk);
         end
         en = 1'b0;
         #1 check_quiet("R6");
      end

      // R6: drop enable mid-bit for several clocks, then one clock
      @(negedge clk);
      presc = 8'd2; prop_len = 3'd2; pseg_len = 3'd1;
      q = 3; p = 3; s = 2;
      b = (1 + p + 2*s) * q;
      en = 1'b1;
      for (int k = 0; k < 13; k++) begin
         #1 check_cycle(k, q, p, s);
         @(negedge clk);
      end
      en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         #1 check_quiet("R6");
         @(negedge clk);
      end
      en = 1'b1;
      for (int k = 0; k < b + 2; k++) begin
         #1 check_cycle(k, q, p, s);
         @(negedge clk);
      end
      en = 1'b0;
      #1 check_quiet("R6");
      @(negedge clk);
      en = 1'b1;
      for (int k = 0; k < b + 2; k++) begin
         #1 check_cycle(k, q, p, s);
         @(negedge clk);
      end
      en = 1'b0;

      // R8: reset reapplied mid-run clears the state
      @(negedge clk);
      en = 1'b1;
      repeat (7) @(negedge clk);
      en = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      #1 check_quiet("R8");
      rst_n = 1'b1;
      @(negedge clk);
      en = 1'b1;
      #1 chk(int'(tx_stb), 1, "R3", "tx_stb after reset release");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule